// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block scans a parallel RGB panel from the pixel clock. It keeps a horizontal pixel counter and a vertical line counter. From these it drives horizontal sync, vertical sync, data-enable, the x/y position of the current active pixel, and single-cycle pulses that mark the first and the last active pixel of a frame. Every sync pulse begins at count zero of its line or frame. The visible window is given by explicit start and end counts, measured from the leading edge of the sync pulse, rather than by porch lengths.

Software programs the window, the totals, the sync end counts and four polarity/edge selects, then starts scanning with an enable pulse. All timing and polarity settings are copied into shadow registers only at the start of scanning or at a frame boundary, so the panel never sees a half-updated frame. A disable request, even a single-cycle pulse, lets the current frame finish. The generator then goes idle and raises a sticky stopped status that software clears explicitly.

Top module: `lcdt_timing_gen`

## Requirements
- R1: After reset the generator is idle: `scan_active`, `scan_stopped`, `hsync`, `vsync`, `de`, `frame_start`, `frame_end`, `data_fall`, `pix_x` and `pix_y` are all 0.
- R2: While scanning, a line lasts `cfg_h_total` clocks, with the horizontal count running from 0 up to `cfg_h_total`-1. The internal horizontal sync is active for counts 0 up to, but not including, `cfg_hsync_end`.
- R3: A frame lasts `cfg_v_total` lines. The internal vertical sync is active for line counts 0 up to, but not including, `cfg_vsync_end`.
- R4: Data-enable is active exactly when the horizontal count lies in [`cfg_h_disp_start`, `cfg_h_disp_end`) and the line count lies in [`cfg_v_disp_start`, `cfg_v_disp_end`). In that case `pix_x` and `pix_y` are the counts minus the respective start values. Otherwise `pix_x` and `pix_y` are 0.
- R5: `frame_start` is high for the one cycle at the first active pixel of the first active line. `frame_end` is high for the one cycle at the last active pixel of the last active line. When the window is a single pixel, both pulses fire in the same cycle.
- R6: `cfg_hsync_low`, `cfg_vsync_low` and `cfg_de_low` each invert their output: a value of 1 makes the signal active-low and makes its idle level 1. `data_fall` reports the captured falling-edge data select.
- R7: Configuration inputs are captured only when scanning starts and at the last count of a frame that is followed by another frame. A change made in the middle of a frame does not alter that frame.
- R8: While idle, `scan_enable`=1 with `scan_disable`=0 starts scanning, and the next cycle shows count (0,0). When `scan_enable` is 1 while `scan_disable` is also 1, the block does not start.
- R9: A `scan_disable` pulse during a frame lets that frame run to its last count. On the following cycle `scan_active` is 0, `scan_stopped` is 1, and every output sits at its idle level.
- R10: `scan_stopped` stays at 1 until a `status_clear` pulse. That pulse clears it on the next cycle. A stop event in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hsync_end | input | CW | Horizontal sync end count (sync width) |
| cfg_vsync_end | input | CW | Vertical sync end line (sync width) |
| cfg_h_total | input | CW | Clocks per line |
| cfg_v_total | input | CW | Lines per frame |
| cfg_h_disp_start | input | CW | First active horizontal count |
| cfg_h_disp_end | input | CW | Horizontal count just past the active area |
| cfg_v_disp_start | input | CW | First active line |
| cfg_v_disp_end | input | CW | Line just past the active area |
| cfg_hsync_low | input | 1 | Horizontal sync active-low select |
| cfg_vsync_low | input | 1 | Vertical sync active-low select |
| cfg_de_low | input | 1 | Data-enable active-low select |
| cfg_data_fall | input | 1 | Drive data on the falling pixel-clock edge |
| scan_enable | input | 1 | Start request |
| scan_disable | input | 1 | Graceful stop request |
| status_clear | input | 1 | Clears the stopped status |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data-enable, polarity applied |
| pix_x | output | CW | Active pixel column |
| pix_y | output | CW | Active pixel row |
| frame_start | output | 1 | First-active-pixel pulse |
| frame_end | output | 1 | Last-active-pixel pulse |
| data_fall | output | 1 | Captured falling-edge data select |
| scan_active | output | 1 | Scanning in progress |
| scan_stopped | output | 1 | Sticky stopped status |

## Verification
Every output is decoded without further registers from the count and shadow registers. A result is therefore due in the same cycle as the count it belongs to: a start request sampled at one rising edge shows count (0,0) right after that edge, and a stop shows up one edge after the last count of the final frame. The bench keeps its own pixel and line position, steps it once per clock, and samples every output on the falling edge that follows each rising edge. Its expected values are always those for the position reached at that rising edge. Mid-frame configuration writes and disable pulses are driven on a falling edge, so they are sampled on the next rising edge.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_RUN  = 1'b1
    } scan_e;

    typedef struct packed {
        logic hs_low;
        logic vs_low;
        logic de_low;
        logic data_fall;
    } pol_t;

endpackage

// File: rtl/lcdt_axis_window.sv
module lcdt_axis_window #(
    parameter int CW = 10
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] sync_end,
    input  logic [CW-1:0] win_start,
    input  logic [CW-1:0] win_end,
    output logic          sync_on,
    output logic          in_win,
    output logic [CW-1:0] offset,
    output logic          at_first,
    output logic          at_last
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_comb begin
        sync_on  = (cnt < sync_end);
        in_win   = (cnt >= win_start) && (cnt < win_end);
        offset   = in_win ? (cnt - win_start) : '0;
        at_first = (cnt == win_start);
        at_last  = (cnt == (win_end - ONE));
    end
endmodule

// File: rtl/lcdt_scan_ctrl.sv
module lcdt_scan_ctrl #(
    parameter int CW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CW-1:0]      in_hse,
    input  logic [CW-1:0]      in_vse,
    input  logic [CW-1:0]      in_ht,
    input  logic [CW-1:0]      in_vt,
    input  logic [CW-1:0]      in_hds,
    input  logic [CW-1:0]      in_hde,
    input  logic [CW-1:0]      in_vds,
    input  logic [CW-1:0]      in_vde,
    input  lcdt_pkg::pol_t     in_pol,
    input  logic               start_req,
    input  logic               stop_req,
    input  logic               clr_req,
    output logic [CW-1:0]      hcnt,
    output logic [CW-1:0]      vcnt,
    output logic               scanning,
    output logic               stopped,
    output logic [CW-1:0]      sh_hse,
    output logic [CW-1:0]      sh_vse,
    output logic [CW-1:0]      sh_ht,
    output logic [CW-1:0]      sh_vt,
    output logic [CW-1:0]      sh_hds,
    output logic [CW-1:0]      sh_hde,
    output logic [CW-1:0]      sh_vds,
    output logic [CW-1:0]      sh_vde,
    output lcdt_pkg::pol_t     sh_pol
);
    import lcdt_pkg::*;

    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] hse;
        logic [CW-1:0] vse;
        logic [CW-1:0] ht;
        logic [CW-1:0] vt;
        logic [CW-1:0] hds;
        logic [CW-1:0] hde;
        logic [CW-1:0] vds;
        logic [CW-1:0] vde;
        pol_t          pol;
    } shadow_t;

    typedef struct packed {
        scan_e         st;
        logic          stopped;
        logic          dis_pend;
        logic [CW-1:0] hcnt;
        logic [CW-1:0] vcnt;
        shadow_t       sh;
    } state_t;

    state_t  s_d, s_q;
    shadow_t cfg_now;
    logic    line_last, frame_last;

    always_comb begin
        cfg_now = '{hse: in_hse, vse: in_vse, ht: in_ht, vt: in_vt,
                    hds: in_hds, hde: in_hde, vds: in_vds, vde: in_vde,
                    pol: in_pol};
        line_last  = (s_q.hcnt == (s_q.sh.ht - ONE));
        frame_last = line_last && (s_q.vcnt == (s_q.sh.vt - ONE));

        s_d = s_q;
        if (clr_req) begin
            s_d.stopped = 1'b0;
        end

        unique case (s_q.st)
            SC_IDLE: begin
                s_d.dis_pend = 1'b0;
                if (start_req && !stop_req) begin
                    s_d.st   = SC_RUN;
                    s_d.hcnt = '0;
                    s_d.vcnt = '0;
                    s_d.sh   = cfg_now;
                end
            end
            SC_RUN: begin
                if (stop_req) begin
                    s_d.dis_pend = 1'b1;
                end
                if (line_last) begin
                    s_d.hcnt = '0;
                    if (frame_last) begin
                        s_d.vcnt = '0;
                        if (s_q.dis_pend || stop_req) begin
                            s_d.st       = SC_IDLE;
                            s_d.stopped  = 1'b1;
                            s_d.dis_pend = 1'b0;
                        end else begin
                            s_d.sh = cfg_now;
                        end
                    end else begin
                        s_d.vcnt = s_q.vcnt + ONE;
                    end
                end else begin
                    s_d.hcnt = s_q.hcnt + ONE;
                end
            end
            default: s_d.st = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hcnt     = s_q.hcnt;
    assign vcnt     = s_q.vcnt;
    assign scanning = (s_q.st == SC_RUN);
    assign stopped  = s_q.stopped;
    assign sh_hse   = s_q.sh.hse;
    assign sh_vse   = s_q.sh.vse;
    assign sh_ht    = s_q.sh.ht;
    assign sh_vt    = s_q.sh.vt;
    assign sh_hds   = s_q.sh.hds;
    assign sh_hde   = s_q.sh.hde;
    assign sh_vds   = s_q.sh.vds;
    assign sh_vde   = s_q.sh.vde;
    assign sh_pol   = s_q.sh.pol;
endmodule

// File: rtl/lcdt_timing_gen.sv
module lcdt_timing_gen #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_hsync_end,
    input  logic [CW-1:0] cfg_vsync_end,
    input  logic [CW-1:0] cfg_h_total,
    input  logic [CW-1:0] cfg_v_total,
    input  logic [CW-1:0] cfg_h_disp_start,
    input  logic [CW-1:0] cfg_h_disp_end,
    input  logic [CW-1:0] cfg_v_disp_start,
    input  logic [CW-1:0] cfg_v_disp_end,
    input  logic          cfg_hsync_low,
    input  logic          cfg_vsync_low,
    input  logic          cfg_de_low,
    input  logic          cfg_data_fall,
    input  logic          scan_enable,
    input  logic          scan_disable,
    input  logic          status_clear,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [CW-1:0] pix_x,
    output logic [CW-1:0] pix_y,
    output logic          frame_start,
    output logic          frame_end,
    output logic          data_fall,
    output logic          scan_active,
    output logic          scan_stopped
);
    import lcdt_pkg::*;

    localparam int NAX = 2;

    logic [CW-1:0] hcnt, vcnt;
    logic          scanning, stopped;
    logic [CW-1:0] sh_hse, sh_vse, sh_ht, sh_vt;
    logic [CW-1:0] sh_hds, sh_hde, sh_vds, sh_vde;
    pol_t          sh_pol, pol_in;

    logic [CW-1:0] ax_cnt   [NAX];
    logic [CW-1:0] ax_sync  [NAX];
    logic [CW-1:0] ax_start [NAX];
    logic [CW-1:0] ax_end   [NAX];
    logic [CW-1:0] ax_off   [NAX];
    logic [NAX-1:0] ax_sync_on, ax_in, ax_first, ax_last;

    logic de_raw, hs_raw, vs_raw;

    assign pol_in = '{hs_low: cfg_hsync_low, vs_low: cfg_vsync_low,
                      de_low: cfg_de_low, data_fall: cfg_data_fall};

    lcdt_scan_ctrl #(.CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_hse    (cfg_hsync_end),
        .in_vse    (cfg_vsync_end),
        .in_ht     (cfg_h_total),
        .in_vt     (cfg_v_total),
        .in_hds    (cfg_h_disp_start),
        .in_hde    (cfg_h_disp_end),
        .in_vds    (cfg_v_disp_start),
        .in_vde    (cfg_v_disp_end),
        .in_pol    (pol_in),
        .start_req (scan_enable),
        .stop_req  (scan_disable),
        .clr_req   (status_clear),
        .hcnt      (hcnt),
        .vcnt      (vcnt),
        .scanning  (scanning),
        .stopped   (stopped),
        .sh_hse    (sh_hse),
        .sh_vse    (sh_vse),
        .sh_ht     (sh_ht),
        .sh_vt     (sh_vt),
        .sh_hds    (sh_hds),
        .sh_hde    (sh_hde),
        .sh_vds    (sh_vds),
        .sh_vde    (sh_vde),
        .sh_pol    (sh_pol)
    );

    assign ax_cnt[0]   = hcnt;
    assign ax_sync[0]  = sh_hse;
    assign ax_start[0] = sh_hds;
    assign ax_end[0]   = sh_hde;
    assign ax_cnt[1]   = vcnt;
    assign ax_sync[1]  = sh_vse;
    assign ax_start[1] = sh_vds;
    assign ax_end[1]   = sh_vde;

    for (genvar a = 0; a < NAX; a++) begin : g_axis
        lcdt_axis_window #(.CW(CW)) u_win (
            .cnt       (ax_cnt[a]),
            .sync_end  (ax_sync[a]),
            .win_start (ax_start[a]),
            .win_end   (ax_end[a]),
            .sync_on   (ax_sync_on[a]),
            .in_win    (ax_in[a]),
            .offset    (ax_off[a]),
            .at_first  (ax_first[a]),
            .at_last   (ax_last[a])
        );
    end

    always_comb begin
        hs_raw      = scanning && ax_sync_on[0];
        vs_raw      = scanning && ax_sync_on[1];
        de_raw      = scanning && (&ax_in);
        hsync       = hs_raw ^ sh_pol.hs_low;
        vsync       = vs_raw ^ sh_pol.vs_low;
        de          = de_raw ^ sh_pol.de_low;
        pix_x       = de_raw ? ax_off[0] : '0;
        pix_y       = de_raw ? ax_off[1] : '0;
        frame_start = de_raw && (&ax_first);
        frame_end   = de_raw && (&ax_last);
        data_fall   = sh_pol.data_fall;
    end

    assign scan_active  = scanning;
    assign scan_stopped = stopped;
endmodule

// File: rtl/lcdt_timing_gen_chk.sv
module lcdt_timing_gen_chk #(
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] hcnt,
    input logic [CW-1:0] vcnt,
    input logic          scanning,
    input logic          stopped,
    input logic          de_raw,
    input logic [CW-1:0] pix_x,
    input logic [CW-1:0] pix_y,
    input logic          frame_start,
    input logic          frame_end,
    input logic [CW-1:0] sh_ht,
    input logic [CW-1:0] sh_vt
);
    localparam logic [CW-1:0] ONE = CW'(1);

    a_r8_start_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scanning) |-> (hcnt == '0) && (vcnt == '0));

    a_r2_line_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && $past(scanning) && hcnt != '0) |-> hcnt == $past(hcnt) + ONE);

    a_r4_pos_zero_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !de_raw |-> (pix_x == '0) && (pix_y == '0));

    a_r5_sof_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (pix_x == '0) && (pix_y == '0));

    a_r9_stop_after_scan: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped) |-> !scanning && $past(scanning));

    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && $past(scanning) && !(hcnt == '0 && vcnt == '0))
            |-> $stable(sh_ht) && $stable(sh_vt));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !scanning |-> !frame_start && !frame_end);
endmodule

bind lcdt_timing_gen lcdt_timing_gen_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hcnt        (hcnt),
    .vcnt        (vcnt),
    .scanning    (scanning),
    .stopped     (stopped),
    .de_raw      (de_raw),
    .pix_x       (pix_x),
    .pix_y       (pix_y),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .sh_ht       (sh_ht),
    .sh_vt       (sh_vt)
);

// File: tb/lcdt_timing_gen_bench.sv
module lcdt_timing_gen_bench;
    localparam int CW = 10;
    localparam int NV = 4;

    typedef struct packed {
        logic [CW-1:0] ht, vt, hse, vse, hds, hde, vds, vde;
        logic hl, vl, dl, fe;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{10'd9,  10'd6, 10'd2, 10'd1, 10'd3, 10'd7,  10'd2, 10'd5, 1'b0, 1'b0, 1'b0, 1'b0},
        '{10'd5,  10'd5, 10'd1, 10'd2, 10'd2, 10'd4,  10'd3, 10'd4, 1'b1, 1'b1, 1'b0, 1'b1},
        '{10'd12, 10'd4, 10'd3, 10'd1, 10'd4, 10'd10, 10'd1, 10'd3, 1'b0, 1'b0, 1'b1, 1'b0},
        '{10'd3,  10'd2, 10'd1, 10'd1, 10'd1, 10'd2,  10'd1, 10'd2, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] cfg_hsync_end, cfg_vsync_end, cfg_h_total, cfg_v_total;
    logic [CW-1:0] cfg_h_disp_start, cfg_h_disp_end, cfg_v_disp_start, cfg_v_disp_end;
    logic cfg_hsync_low, cfg_vsync_low, cfg_de_low, cfg_data_fall;
    logic scan_enable, scan_disable, status_clear;
    logic hsync, vsync, de, frame_start, frame_end, data_fall, scan_active, scan_stopped;
    logic [CW-1:0] pix_x, pix_y;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lcdt_timing_gen #(.CW(CW)) u_lcdt_timing_gen (
        .clk(clk), .rst_n(rst_n),
        .cfg_hsync_end(cfg_hsync_end), .cfg_vsync_end(cfg_vsync_end),
        .cfg_h_total(cfg_h_total), .cfg_v_total(cfg_v_total),
        .cfg_h_disp_start(cfg_h_disp_start), .cfg_h_disp_end(cfg_h_disp_end),
        .cfg_v_disp_start(cfg_v_disp_start), .cfg_v_disp_end(cfg_v_disp_end),
        .cfg_hsync_low(cfg_hsync_low), .cfg_vsync_low(cfg_vsync_low),
        .cfg_de_low(cfg_de_low), .cfg_data_fall(cfg_data_fall),
        .scan_enable(scan_enable), .scan_disable(scan_disable),
        .status_clear(status_clear),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
        .frame_start(frame_start), .frame_end(frame_end), .data_fall(data_fall),
        .scan_active(scan_active), .scan_stopped(scan_stopped)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input vec_t c);
        cfg_h_total = c.ht;       cfg_v_total = c.vt;
        cfg_hsync_end = c.hse;    cfg_vsync_end = c.vse;
        cfg_h_disp_start = c.hds; cfg_h_disp_end = c.hde;
        cfg_v_disp_start = c.vds; cfg_v_disp_end = c.vde;
        cfg_hsync_low = c.hl;     cfg_vsync_low = c.vl;
        cfg_de_low = c.dl;        cfg_data_fall = c.fe;
    endtask

    // expected outputs for position (h,v) computed from the requirements
    task automatic check_run(input vec_t c, input int h, input int v);
        bit hs, vs, dv;
        hs = h < int'(c.hse);
        vs = v < int'(c.vse);
        dv = (h >= int'(c.hds)) && (h < int'(c.hde)) && (v >= int'(c.vds)) && (v < int'(c.vde));
        chk("R8 scan_active", int'(scan_active), 1);
        chk("R2 hsync", int'(hsync), int'(hs ^ c.hl));
        chk("R3 vsync", int'(vsync), int'(vs ^ c.vl));
        chk("R4 de", int'(de), int'(dv ^ c.dl));
        chk("R4 pix_x", int'(pix_x), dv ? h - int'(c.hds) : 0);
        chk("R4 pix_y", int'(pix_y), dv ? v - int'(c.vds) : 0);
        chk("R5 frame_start", int'(frame_start), int'(dv && h == int'(c.hds) && v == int'(c.vds)));
        chk("R5 frame_end", int'(frame_end),
            int'(dv && h == int'(c.hde) - 1 && v == int'(c.vde) - 1));
        chk("R6 data_fall", int'(data_fall), int'(c.fe));
    endtask

    task automatic check_idle(input vec_t c, input string tag);
        chk({tag, " scan_active"}, int'(scan_active), 0);
        chk({tag, " R6 hsync idle"}, int'(hsync), int'(c.hl));
        chk({tag, " R6 vsync idle"}, int'(vsync), int'(c.vl));
        chk({tag, " R6 de idle"}, int'(de), int'(c.dl));
        chk({tag, " pix_x"}, int'(pix_x), 0);
        chk({tag, " pix_y"}, int'(pix_y), 0);
        chk({tag, " pulses"}, int'(frame_start) + int'(frame_end), 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        vec_t zero_cfg;
        zero_cfg = '0;
        set_cfg(zero_cfg);
        scan_enable = 1'b0; scan_disable = 1'b0; status_clear = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_idle(zero_cfg, "R1");
        chk("R1 scan_stopped", int'(scan_stopped), 0);
        chk("R1 data_fall", int'(data_fall), 0);

        // R8: enable together with disable must not start
        set_cfg(VECS[0]);
        scan_enable = 1'b1; scan_disable = 1'b1;
        @(negedge clk);
        scan_enable = 1'b0; scan_disable = 1'b0;
        chk("R8 blocked start", int'(scan_active), 0);
        chk("R8 blocked hsync", int'(hsync), 0);

        // table walk: start, two frames, mid-frame change and stop request in frame 1
        for (int i = 0; i < NV; i++) begin
            vec_t c;
            c = VECS[i];
            set_cfg(c);
            scan_enable = 1'b1; status_clear = 1'b1;
            @(negedge clk);
            scan_enable = 1'b0; status_clear = 1'b0;
            chk("R10 cleared at start", int'(scan_stopped), 0);
            for (int f = 0; f < 2; f++) begin
                for (int v = 0; v < int'(c.vt); v++) begin
                    for (int h = 0; h < int'(c.ht); h++) begin
                        check_run(c, h, v);
                        if (f == 1 && v == 1 && h == 0) begin
                            scan_disable = 1'b1;
                            set_cfg(VECS[(i + 1) % NV]); // R7 mid-frame write
                        end
                        @(negedge clk);
                        scan_disable = 1'b0;
                    end
                end
            end
            // R9 stopped after the frame completed
            check_idle(c, "R9");
            chk("R9 scan_stopped", int'(scan_stopped), 1);
        end

        // R10 status holds while idle, then clears on request
        repeat (3) @(negedge clk);
        chk("R10 stopped held", int'(scan_stopped), 1);
        chk("R10 still idle", int'(scan_active), 0);
        status_clear = 1'b1;
        @(negedge clk);
        status_clear = 1'b0;
        chk("R10 stopped cleared", int'(scan_stopped), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule